// File: doc/BRIEF.md
# Flash Status-Polling Completion Engine

This block sits on the host side of a parallel flash interface. After the host has written a program or erase command sequence, it pulses `start` with the operation type, the address to poll and, for a program, the data it wrote. The engine then reads that address over a one-outstanding read handshake until the most significant data bit reports completion, or until a poll budget runs out. The poll address must be the programmed location for a program, or any location inside a sector being erased for an erase.

During a program the status bit reads as the inverse of the written value's top bit until the operation ends. During an erase the status bit reads 0 until the operation ends and 1 afterwards. The top bit can settle before the lower bits do. For that reason a poll that reports completion is never trusted as data: the engine always issues one more full read, and it judges pass or fail on that read alone. A short settle delay after `start` keeps the first poll clear of the command's final write strobe.

Top module: `flash_poll_engine`

## Requirements
- R1: After reset, `rd_req`, `busy`, `done`, `pass`, `fail` and `timeout` are all 0.
- R2: An accepted `start` (sampled high while idle) raises `busy`. The first `rd_req` is asserted on the (SETTLE_CYC+1)th rising edge after the edge that accepted `start`, and never earlier.
- R3: `rd_req` is a single-cycle pulse. At most one read is in flight: no new `rd_req` is raised until `rd_valid` has returned data for the previous one. `rd_addr` always equals the poll address latched at `start`.
- R4: With `op_erase`=0 (program), a poll is a completion hit when `rd_data[DW-1]` equals `exp_data[DW-1]`. Any other poll is followed by another poll.
- R5: With `op_erase`=1 (erase), a poll is a completion hit when `rd_data[DW-1]` is 1. A 0 in that bit is followed by another poll.
- R6: After a hit, exactly one confirming read of the same address is issued. The lower bits of the hit poll never affect the verdict.
- R7: For a program, `pass` is set if the confirming read equals `exp_data` in all bits, and `fail` is set otherwise. For an erase, `pass` is set if the confirming read is all ones, and `fail` is set otherwise. `timeout` stays 0 in both cases.
- R8: If MAX_POLLS status polls all miss, the engine finishes with `fail`=1 and `timeout`=1. It issues no further reads, so no more than MAX_POLLS status polls are ever made.
- R9: `done` is high for exactly one cycle per accepted `start`, with exactly one of `pass` and `fail` set. `pass`, `fail` and `timeout` hold their values until the next accepted `start`.
- R10: A `start` pulse while `busy` is 1 is ignored. The in-flight operation keeps its address, type and expected data.
- R11: An `rd_valid` pulse that arrives while no read is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling; accepted only when idle |
| op_erase | input | 1 | 1 = erase operation, 0 = program operation |
| poll_addr | input | AW | Address to poll |
| exp_data | input | DW | Data written by the program operation |
| rd_req | output | 1 | One-cycle read request toward the flash bus |
| rd_addr | output | AW | Address for the read request |
| rd_valid | input | 1 | Read data valid strobe from the flash bus |
| rd_data | input | DW | Read data from the flash bus |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation completed and verified |
| fail | output | 1 | Operation failed verification or timed out |
| timeout | output | 1 | Poll budget exhausted without completion |

## Verification
The bench builds the engine with DW=8, AW=16, MAX_POLLS=6 and SETTLE_CYC=3. The small poll budget lets the exhaustion path be reached in a few dozen cycles. The non-zero settle delay makes the position of the first read request measurable against the start edge. A scripted flash responder returns a busy status bit, then a hit word with deliberately wrong lower bits, then a final word. This shows that the verdict comes only from the confirming read, for programs of both top-bit polarities and for erases.

// File: rtl/poll_pkg.sv
package poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE_READ,
    ST_WAIT_DATA,
    ST_CHECK,
    ST_CONFIRM_READ,
    ST_DONE
  } poll_state_t;

endpackage

// File: rtl/poll_settle_timer.sv
module poll_settle_timer #(
  parameter int SETTLE_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int SW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= SW'(SETTLE_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0) && !load;

  AST_SETTLE_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= SW'(SETTLE_CYC)); // R2

endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
  parameter int MAX_POLLS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic incr,
  output logic exhausted
);
  localparam int CW = (MAX_POLLS < 1) ? 1 : $clog2(MAX_POLLS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (incr && (cnt_q != CW'(MAX_POLLS))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign exhausted = (cnt_q == CW'(MAX_POLLS));

  AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(MAX_POLLS)); // R8

  AST_NO_POLL_PAST_CAP: assert property (@(posedge clk) disable iff (rst)
    exhausted |-> !incr); // R8

endmodule

// File: rtl/poll_judge.sv
module poll_judge #(
  parameter int DW = 8
) (
  input  logic          op_erase,
  input  logic [DW-1:0] exp_word,
  input  logic [DW-1:0] rd_word,
  output logic          status_hit,
  output logic          word_ok
);
  localparam int SB = DW - 1;

  always_comb begin
    if (op_erase) begin
      status_hit = rd_word[SB];
      word_ok    = &rd_word;
    end else begin
      status_hit = (rd_word[SB] == exp_word[SB]);
      word_ok    = (rd_word == exp_word);
    end
  end

endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
  import poll_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AW         = 24,
  parameter int MAX_POLLS  = 16,
  parameter int SETTLE_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_erase,
  input  logic [AW-1:0] poll_addr,
  input  logic [DW-1:0] exp_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic          timeout
);

  poll_state_t   state_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;
  logic [DW-1:0] data_q;
  logic          erase_q;
  logic          confirm_q;
  logic          rd_req_q;
  logic          busy_q;
  logic          done_q;
  logic          pass_q;
  logic          fail_q;
  logic          timeout_q;

  logic accept;
  logic settle_expired;
  logic poll_issue;
  logic budget_out;
  logic status_hit;
  logic word_ok;

  assign accept     = (state_q == ST_IDLE) && start;
  assign poll_issue = (state_q == ST_ISSUE_READ) && settle_expired;

  poll_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .expired (settle_expired)
  );

  poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept),
    .incr      (poll_issue),
    .exhausted (budget_out)
  );

  poll_judge #(.DW(DW)) u_judge (
    .op_erase   (erase_q),
    .exp_word   (exp_q),
    .rd_word    (data_q),
    .status_hit (status_hit),
    .word_ok    (word_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      exp_q     <= '0;
      data_q    <= '0;
      erase_q   <= 1'b0;
      confirm_q <= 1'b0;
      rd_req_q  <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
      fail_q    <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      rd_req_q <= 1'b0;
      done_q   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            addr_q    <= poll_addr;
            exp_q     <= exp_data;
            erase_q   <= op_erase;
            confirm_q <= 1'b0;
            busy_q    <= 1'b1;
            pass_q    <= 1'b0;
            fail_q    <= 1'b0;
            timeout_q <= 1'b0;
            state_q   <= ST_ISSUE_READ;
          end
        end
        ST_ISSUE_READ: begin
          if (settle_expired) begin
            rd_req_q <= 1'b1;
            state_q  <= ST_WAIT_DATA;
          end
        end
        ST_WAIT_DATA: begin
          if (rd_valid) begin
            data_q  <= rd_data;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (confirm_q) begin
            done_q  <= 1'b1;
            pass_q  <= word_ok;
            fail_q  <= !word_ok;
            state_q <= ST_DONE;
          end else if (status_hit) begin
            confirm_q <= 1'b1;
            state_q   <= ST_CONFIRM_READ;
          end else if (budget_out) begin
            done_q    <= 1'b1;
            fail_q    <= 1'b1;
            timeout_q <= 1'b1;
            state_q   <= ST_DONE;
          end else begin
            state_q <= ST_ISSUE_READ;
          end
        end
        ST_CONFIRM_READ: begin
          rd_req_q <= 1'b1;
          state_q  <= ST_WAIT_DATA;
        end
        ST_DONE: begin
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req  = rd_req_q;
  assign rd_addr = addr_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign pass    = pass_q;
  assign fail    = fail_q;
  assign timeout = timeout_q;

  AST_START_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    accept |=> !rd_req); // R2

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req); // R3

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_DATA && !rd_valid) |=> !rd_req); // R3

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy && state_q != ST_IDLE) |=> $stable(rd_addr)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
    done |-> (pass != fail)); // R9

  AST_TIMEOUT_FAIL: assert property (@(posedge clk) disable iff (rst)
    timeout |-> fail); // R8

endmodule

// File: tb/flash_poll_engine_tb.sv
module flash_poll_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int AW         = 16;
  localparam int MAX_POLLS  = 6;
  localparam int SETTLE_CYC = 3;
  localparam int LAT        = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic          op_erase;
  logic [AW-1:0] poll_addr;
  logic [DW-1:0] exp_data;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          busy, done, pass, fail, timeout;

  int checks = 0;
  int errors = 0;

  // responder script
  logic          m_erase;
  logic [DW-1:0] m_exp;
  logic [DW-1:0] m_final;
  logic [AW-1:0] m_addr;
  int            m_busy;
  int            nreads;
  int            addr_bad;
  int            overlap;
  logic          resp_quiet;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_poll_engine #(
    .DW(DW), .AW(AW), .MAX_POLLS(MAX_POLLS), .SETTLE_CYC(SETTLE_CYC)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .op_erase(op_erase),
    .poll_addr(poll_addr), .exp_data(exp_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done), .pass(pass), .fail(fail), .timeout(timeout)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] resp_word(input int k);
    logic good;
    good = m_erase ? 1'b1 : m_exp[DW-1];
    if (k <= m_busy)
      resp_word = {~good, 7'(k * 5) ^ 7'h2A};
    else if (k == m_busy + 1)
      resp_word = {good, ~m_final[DW-2:0]};
    else
      resp_word = m_final;
  endfunction

  // flash bus model: one response per request, LAT cycles later
  initial begin
    rd_valid = 1'b0;
    rd_data  = '0;
    forever begin
      @(negedge clk);
      if (rd_req && !resp_quiet) begin
        nreads++;
        if (rd_addr != m_addr) addr_bad++;
        for (int i = 0; i < LAT; i++) begin
          @(negedge clk);
          if (rd_req) overlap++;
        end
        rd_valid = 1'b1;
        rd_data  = resp_word(nreads);
        @(negedge clk);
        rd_valid = 1'b0;
        rd_data  = '0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Runs one operation; optionally pulses a conflicting start mid-flight.
  task automatic run_case(input string tag, input bit erase, input logic [AW-1:0] addr,
                          input logic [DW-1:0] exp, input int busy_n, input logic [DW-1:0] fin,
                          input bit exp_pass, input bit exp_to, input int exp_reads,
                          input bit poke_start);
    int first_req;
    int wait_cyc;
    int done_cnt;
    m_erase = erase; m_exp = exp; m_final = fin; m_addr = addr; m_busy = busy_n;
    nreads = 0; addr_bad = 0; overlap = 0;
    @(negedge clk);
    op_erase = erase; poll_addr = addr; exp_data = exp; start = 1'b1;
    first_req = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      first_req++;
    end while (!rd_req && first_req < 100);
    check(first_req == SETTLE_CYC + 2, {tag, " R2 first read delay"}, first_req, SETTLE_CYC + 2);
    check(busy == 1'b1, {tag, " R2 busy"}, busy, 1);
    if (poke_start) begin
      @(negedge clk);
      start = 1'b1; op_erase = ~erase; poll_addr = ~addr; exp_data = ~exp;
      @(negedge clk);
      start = 1'b0;
    end
    wait_cyc = 0;
    done_cnt = 0;
    while (!done && wait_cyc < 2000) begin
      @(negedge clk);
      wait_cyc++;
    end
    check(done == 1'b1, {tag, " R9 done seen"}, done, 1);
    check(pass == exp_pass, {tag, " R7 pass"}, pass, exp_pass);
    check(fail == !exp_pass, {tag, " R7 fail"}, fail, !exp_pass);
    check(timeout == exp_to, {tag, " R8 timeout"}, timeout, exp_to);
    for (int i = 0; i < 6; i++) begin
      if (done) done_cnt++;
      @(negedge clk);
    end
    check(done_cnt == 1, {tag, " R9 done width"}, done_cnt, 1);
    check(pass == exp_pass && timeout == exp_to, {tag, " R9 verdict held"}, pass, exp_pass);
    check(busy == 1'b0, {tag, " R9 idle after done"}, busy, 0);
    check(nreads == exp_reads, {tag, " R6 read count"}, nreads, exp_reads);
    check(addr_bad == 0, {tag, " R3 R10 read address"}, addr_bad, 0);
    check(overlap == 0, {tag, " R3 one in flight"}, overlap, 0);
  endtask

  task automatic test_reset();
    check(rd_req == 0 && busy == 0 && done == 0, "R1 reset ctrl", {rd_req, busy, done}, 0);
    check(pass == 0 && fail == 0 && timeout == 0, "R1 reset verdict", {pass, fail, timeout}, 0);
  endtask

  task automatic test_timeout();
    run_case("timeout", 1'b0, 16'h0440, 8'h81, 1000, 8'h81, 1'b0, 1'b1, MAX_POLLS, 1'b0);
    repeat (20) @(negedge clk);
    check(nreads == MAX_POLLS, "R8 no reads after timeout", nreads, MAX_POLLS);
  endtask

  task automatic test_stray_valid();
    m_erase = 1'b0; m_exp = 8'h3C; m_final = 8'h3C; m_addr = 16'h0777; m_busy = 1;
    nreads = 0; addr_bad = 0; overlap = 0;
    @(negedge clk);
    op_erase = 1'b0; poll_addr = 16'h0777; exp_data = 8'h3C; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // responder is idle here; inject a stray completion word during settle
    resp_quiet = 1'b1;
    rd_valid = 1'b1; rd_data = 8'h3C;
    @(negedge clk);
    rd_valid = 1'b0; rd_data = '0;
    resp_quiet = 1'b0;
    while (!done) @(negedge clk);
    check(pass == 1'b1, "R11 stray valid ignored pass", pass, 1);
    @(negedge clk);
    @(negedge clk);
    check(nreads == 3, "R11 stray valid ignored reads", nreads, 3);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; op_erase = 1'b0; poll_addr = '0; exp_data = '0;
    resp_quiet = 1'b0; nreads = 0; m_busy = 0; m_erase = 0; m_exp = '0; m_final = '0; m_addr = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    // R6: hit on first poll with stale low bits, confirm decides
    run_case("prog_fast", 1'b0, 16'h1234, 8'hA5, 0, 8'hA5, 1'b1, 1'b0, 2, 1'b0);
    // R4: top bit 0 written, busy polls read 1
    run_case("prog_busy", 1'b0, 16'h0102, 8'h35, 3, 8'h35, 1'b1, 1'b0, 5, 1'b0);
    // R7: confirm mismatch in low bit
    run_case("prog_bad", 1'b0, 16'h2222, 8'hC3, 1, 8'hC2, 1'b0, 1'b0, 3, 1'b0);
    // R5: erase completes when top bit reads 1
    run_case("erase_ok", 1'b1, 16'h8000, 8'h00, 2, 8'hFF, 1'b1, 1'b0, 4, 1'b0);
    // R7: erase confirm not all ones
    run_case("erase_bad", 1'b1, 16'h8010, 8'h00, 0, 8'hFE, 1'b0, 1'b0, 2, 1'b0);
    test_timeout();
    // R10: conflicting start while busy
    run_case("busy_start", 1'b0, 16'h0ABC, 8'h5A, 2, 8'h5A, 1'b1, 1'b0, 4, 1'b1);
    test_stray_valid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule